// File: doc/BRIEF.md
# Static RAM with Bulk Clear

A synchronous 1024-word by 4-bit memory with a dedicated write-data bus and a dedicated read-data bus, so no bidirectional multiplexing is involved. All control inputs are active low: chip select, write enable, output enable and a bulk-clear request. Stored words sit in a 64-row by 64-column arrangement. The upper six address bits pick a row, and the lower four pick a 4-bit group inside that row.

A bulk clear is requested by holding chip select and the clear input low together. The first clocked cycle of the request zeroes rows 0 to 31, and the second zeroes rows 32 to 63, so the whole array reads as zero after two cycles. When chip select is high, the clear input is ignored. A global clear line can therefore be shared among several instances, and only the selected ones are wiped.

Reads are registered. The read-data bus carries a valid flag that stands in for a tri-state enable. The flag is low, and the bus is driven to zero, whenever the memory is deselected, output enable is high, a write is in progress or a clear is requested.

Top module: `sram_bulk_clear`

## Requirements
- R1: The memory holds 1024 words of 4 bits, selected by a 10-bit address. A word written at an address is returned by a later read of that address.
- R2: Address bits [9:4] select one of 64 rows and bits [3:0] select a 4-bit group in the row. Rows 0 to 31 hold addresses 0 to 511.
- R3: A write occurs on the clock edge at which cs_ni=0, we_ni=0 and clr_ni=1, storing data_i at addr_i. With cs_ni=1, no write occurs.
- R4: When cs_ni=0, oe_ni=0, we_ni=1 and clr_ni=1 at an edge, data_oe_o=1 and data_o holds the word at addr_i from that edge until the next edge.
- R5: A clear request (cs_ni=0, clr_ni=0) held for two consecutive edges makes every word read as zero until it is written again.
- R6: With cs_ni=1, clr_ni=0 has no effect on stored data.
- R7: After an edge at which cs_ni=1, oe_ni=1, we_ni=0 or clr_ni=0, data_oe_o=0 and data_o=0.
- R8: While rst_ni=0, the array is all zero, data_oe_o=0 and data_o=0.
- R9: When clr_ni=0 and we_ni=0 with cs_ni=0, no write takes place and the clear proceeds.
- R10: A clear request lasting a single edge zeroes only rows 0 to 31 (addresses 0 to 511). Addresses 512 to 1023 keep their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| clr_ni | input | 1 | Bulk-clear request, active low |
| addr_i | input | 10 | Word address |
| data_i | input | 4 | Write data |
| data_o | output | 4 | Read data, zero when not valid |
| data_oe_o | output | 1 | Read data valid (tri-state enable) |

## Verification
Writes and clear phases land on the edge at which they are presented, so their effects are only visible through a later read. Read data and the valid flag change at the edge that samples the read. The bench drives inputs on the falling edge and advances its reference model after the rising edge. It then compares both outputs on the following falling edge, which puts every check exactly one register after its stimulus. The single-edge clear and the two-edge clear are checked by reading back every address across the 511/512 boundary and the whole array.

// File: rtl/sram_bc_pkg.sv
package sram_bc_pkg;
  localparam int AW       = 10;
  localparam int DW       = 4;
  localparam int ROW_BITS = 6;
  localparam int COL_BITS = AW - ROW_BITS;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int ROW_W    = (1 << COL_BITS) * DW;
endpackage

// File: rtl/sram_addr_split.sv
module sram_addr_split #(
  parameter int AW       = sram_bc_pkg::AW,
  parameter int ROW_BITS = sram_bc_pkg::ROW_BITS,
  localparam int COL_BITS = AW - ROW_BITS
) (
  input  logic [AW-1:0]       addr_i,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o
);
  assign row_o = addr_i[AW-1:COL_BITS];
  assign col_o = addr_i[COL_BITS-1:0];
endmodule

// File: rtl/sram_clear_ctrl.sv
module sram_clear_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clr_lo_o,
  output logic clr_hi_o
);
  logic half_q;

  // first request cycle clears lower rows, second clears upper rows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= req_i & ~half_q;
  end

  assign clr_lo_o = req_i & ~half_q;
  assign clr_hi_o = req_i & half_q;

  // R10
  lone_clear_lo_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !clr_hi_o);
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DW       = sram_bc_pkg::DW,
  parameter int ROW_BITS = sram_bc_pkg::ROW_BITS,
  parameter int COL_BITS = sram_bc_pkg::COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int ROW_W   = (1 << COL_BITS) * DW,
  localparam int BITS    = ROWS * ROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [COL_BITS-1:0] col_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic                clr_lo_i,
  input  logic                clr_hi_i,
  output logic [DW-1:0]       rdata_o
);
  logic [ROW_W-1:0] rows_q [ROWS];
  logic [BITS-1:0]  flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam bit LOWER = (r < ROWS / 2);
    logic clr_row;
    if (LOWER) begin : g_lo
      assign clr_row = clr_lo_i;
    end else begin : g_hi
      assign clr_row = clr_hi_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rows_q[r] <= '0;
      else if (clr_row)                           rows_q[r] <= '0;
      else if (we_i && row_i == ROW_BITS'(r))     rows_q[r][col_i*DW +: DW] <= wdata_i;
    end

    assign flat[r*ROW_W +: ROW_W] = rows_q[r];
  end

  assign rdata_o = rows_q[row_i][col_i*DW +: DW];

  // R5
  full_clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hi_i |=> (flat == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_lo_i && !clr_hi_i) |=> $stable(flat));
  // R3
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_lo_i && !clr_hi_i) |=>
      flat[int'({$past(row_i), $past(col_i)})*DW +: DW] == $past(wdata_i));
endmodule

// File: rtl/sram_read_port.sv
module sram_read_port #(
  parameter int DW = sram_bc_pkg::DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      data_o <= rd_en_i ? rdata_i : '0;
      oe_o   <= rd_en_i;
    end
  end

  // R7
  off_when_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!oe_o && data_o == '0));
  // R4
  read_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (oe_o && data_o == $past(rdata_i)));
endmodule

// File: rtl/sram_bulk_clear.sv
module sram_bulk_clear #(
  parameter int AW       = sram_bc_pkg::AW,
  parameter int DW       = sram_bc_pkg::DW,
  parameter int ROW_BITS = sram_bc_pkg::ROW_BITS,
  localparam int COL_BITS = AW - ROW_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          clr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic [ROW_BITS-1:0] row;
  logic [COL_BITS-1:0] col;
  logic                clr_req, wr_en, rd_en, clr_lo, clr_hi;
  logic [DW-1:0]       rdata;

  assign clr_req = ~cs_ni & ~clr_ni;
  assign wr_en   = ~cs_ni & ~we_ni & clr_ni;   // clear has priority over write
  assign rd_en   = ~cs_ni & ~oe_ni & we_ni & clr_ni;

  sram_addr_split #(.AW(AW), .ROW_BITS(ROW_BITS)) i_split (
    .addr_i (addr_i),
    .row_o  (row),
    .col_o  (col)
  );

  sram_clear_ctrl i_clr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (clr_req),
    .clr_lo_o (clr_lo),
    .clr_hi_o (clr_hi)
  );

  sram_array #(.DW(DW), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .row_i    (row),
    .col_i    (col),
    .wdata_i  (data_i),
    .clr_lo_i (clr_lo),
    .clr_hi_i (clr_hi),
    .rdata_o  (rdata)
  );

  sram_read_port #(.DW(DW)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en),
    .rdata_i (rdata),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );

  // R9
  clear_beats_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !we_ni) |-> !wr_en);
endmodule

// File: tb/test_sram_bulk_clear.sv
module test_sram_bulk_clear;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_ni, cs_ni, we_ni, oe_ni, clr_ni;
  logic [9:0] addr;
  logic [3:0] din, data_o;
  logic       data_oe_o;

  always #4 clk = ~clk;

  sram_bulk_clear i_sram_bulk_clear (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .clr_ni(clr_ni), .addr_i(addr), .data_i(din), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  int         n_tests = 0, n_fail = 0, clr_run = 0;
  bit         done = 1'b0;
  logic [3:0] mem_m [1024];
  logic [3:0] exp_d;
  logic       exp_oe;

  task automatic check(input string req);
    n_tests++;
    if (data_o !== exp_d || data_oe_o !== exp_oe) begin
      n_fail++;
      $display("FAIL %s: data_o=%h data_oe_o=%b expected %h %b", req, data_o, data_oe_o, exp_d, exp_oe);
    end
  endtask

  task automatic step(input logic cs, we, oe, clr, input logic [9:0] a,
                      input logic [3:0] d, input string req);
    cs_ni = cs; we_ni = we; oe_ni = oe; clr_ni = clr; addr = a; din = d;
    @(posedge clk);
    if (!cs && !oe && we && clr) begin exp_oe = 1'b1; exp_d = mem_m[a]; end
    else begin exp_oe = 1'b0; exp_d = 4'h0; end
    if (!cs && !clr) begin
      clr_run++;
      if (clr_run % 2 == 1) for (int i = 0; i < 512; i++) mem_m[i] = 4'h0;
      else                  for (int i = 512; i < 1024; i++) mem_m[i] = 4'h0;
    end else begin
      clr_run = 0;
      if (!cs && !we) mem_m[a] = d;
    end
    @(negedge clk);
    check(req);
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] d, input string req);
    step(1'b0, 1'b0, 1'b1, 1'b1, a, d, req);
  endtask

  task automatic rd(input logic [9:0] a, input string req);
    step(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0, req);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = 4'h0;
    exp_d = 4'h0; exp_oe = 1'b0;
    rst_ni = 1'b0; cs_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1; clr_ni = 1'b1;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R8 reset outputs");
    rst_ni = 1'b1;
    @(negedge clk);
    rd(10'd37, "R8 array zero after reset");

    // R1 R3 R4: random writes and reads
    for (int i = 0; i < 300; i++) wr(10'($urandom), 4'($urandom), "R3 write");
    for (int i = 0; i < 300; i++) rd(10'($urandom), "R1 readback");
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 2) wr(10'($urandom), 4'($urandom), "R3 mixed write");
      else              rd(10'($urandom), "R4 mixed read");
    end
    wr(10'd0, 4'hA, "R3 write low edge");
    wr(10'd1023, 4'h5, "R3 write high edge");
    rd(10'd0, "R4 read addr 0");
    rd(10'd1023, "R4 read addr 1023");

    // R7: gating
    step(1'b0, 1'b1, 1'b1, 1'b1, 10'd0, 4'h0, "R7 oe high");
    step(1'b1, 1'b1, 1'b0, 1'b1, 10'd0, 4'h0, "R7 cs high");
    step(1'b0, 1'b0, 1'b0, 1'b1, 10'd5, 4'h9, "R7 we low");
    rd(10'd5, "R3 write under oe low");

    // R3: write with cs high ignored
    step(1'b1, 1'b0, 1'b1, 1'b1, 10'd0, 4'h3, "R3 deselected write");
    rd(10'd0, "R3 deselected write ignored");

    // R6: clear with cs high
    for (int i = 0; i < 16; i++) wr(10'(i * 64 + 3), 4'(i | 1), "R6 fill");
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 4'h0, "R6 clr deselected");
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'd0, 4'h0, "R6 clr deselected");
    for (int i = 0; i < 16; i++) rd(10'(i * 64 + 3), "R6 data kept");

    // R9 + R10: write and clear together, single-edge clear
    wr(10'd700, 4'h5, "R9 setup");
    for (int i = 500; i < 524; i++) wr(10'(i), 4'(i | 8), "R2 fill");
    step(1'b0, 1'b0, 1'b0, 1'b0, 10'd700, 4'hA, "R9 clr with we");
    step(1'b1, 1'b1, 1'b1, 1'b1, 10'd0, 4'h0, "R7 idle");
    rd(10'd700, "R9 write suppressed");
    for (int i = 500; i < 524; i++) rd(10'(i), "R10 R2 half boundary");

    // R5: two-edge clear, full readback
    for (int i = 0; i < 200; i++) wr(10'($urandom), 4'($urandom), "R5 fill");
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd3, 4'h0, "R7 clear phase 1");
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd3, 4'h0, "R7 clear phase 2");
    for (int i = 0; i < 1024; i++) rd(10'(i), "R5 full clear");
    wr(10'd600, 4'hC, "R5 write after clear");
    rd(10'd600, "R5 new data");
    rd(10'd601, "R5 neighbour still zero");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule